// File: doc/BRIEF.md
# Shift-Row Issue Scoreboard

This block decides, for an in-order pipeline of fixed depth, whether the instruction waiting at the issue point may enter the pipeline this cycle. Each architectural register owns a page of two rows, each as wide as the pipeline is deep. The position row carries a single marker that shows which stage the register's in-flight producer occupies. The readiness row carries a timeline of cycles, counted from now, in which a consumer that enters now would find the result available. Both rows move one step on every clock. The issue test therefore reads one bit per source. It needs no comparison of a source tag against every destination in flight.

A candidate presents a destination register, the stage at which its own result will first exist, and up to two sources. Each source comes with an enable and the stage at which the candidate first needs that operand. The block answers in the same cycle. It raises `issueOk`, and for each source it gives a one-hot stage select that tells the datapath where to take a forwarded value. An all-zero select means the register file supplies that operand. When a candidate fires, its destination page is loaded. Stages are numbered from 1 (the first stage after issue) to `NUM_STAGES`.

A candidate can forward an operand from a producer that writes the same register the candidate writes. In that case `wbSuppress` tells the datapath that the older producer need not write the register file.

Top module: `sb_scoreboard`

## Requirements
- R1: After synchronous reset every page is empty. Every source is then ready, both forward selects are zero and `wbSuppress` is low.
- R2: In the cycle after a candidate fires with destination d, a source naming d has forward select bit 0 set. Bit k of a forward select means stage k+1.
- R3: While a producer is in flight and no newer producer replaces it, the one-hot forward select for its register moves up one bit per clock. It has at most one bit set at all times.
- R4: When a producer's marker leaves stage `NUM_STAGES`, its page empties: the forward select goes to zero and the source is ready.
- R5: Let a producer sit at stage E with its result first available at stage A, and let a consumer need the value at stage N. With D = (A − E) − N + 1, `issueOk` is high when D ≤ 0 for every enabled in-flight source, and is decided combinationally in the same cycle.
- R6: Let a producer issue with A = 3, so that two cycles later it sits at stage 2. A consumer that needs the value at stage 2 then gets `issueOk` high.
- R7: A source whose enable is low never stalls issue, and its forward select reads zero.
- R8: With `ZERO_REG_CONST` set, register 0 is never in flight. Loading it has no effect, and a source naming it is ready with a zero select.
- R9: A candidate that fires to a register that already has a producer in flight replaces that producer. In the next cycle the select is back at bit 0, and readiness follows the new availability stage.
- R10: `wbSuppress` is high exactly when a candidate fires and one of its enabled sources names its own destination while that register has a producer in flight.
- R11: A candidate fires only when `issueValid` and `issueOk` are both high. A stalled or invalid candidate leaves every page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears all pages |
| issueValid | input | 1 | A candidate is presented |
| issueDst | input | $clog2(NUM_REGS) | Destination register of the candidate |
| issueAvail | input | $clog2(NUM_STAGES+1) | Stage where the candidate's result first exists (1..NUM_STAGES) |
| src0En | input | 1 | Source 0 is used |
| src0Reg | input | $clog2(NUM_REGS) | Source 0 register |
| src0Need | input | $clog2(NUM_STAGES+1) | Stage where source 0 is first needed |
| src1En | input | 1 | Source 1 is used |
| src1Reg | input | $clog2(NUM_REGS) | Source 1 register |
| src1Need | input | $clog2(NUM_STAGES+1) | Stage where source 1 is first needed |
| issueOk | output | 1 | Candidate may issue this cycle |
| fwdSel0 | output | NUM_STAGES | One-hot forwarding stage for source 0, zero means register file |
| fwdSel1 | output | NUM_STAGES | One-hot forwarding stage for source 1, zero means register file |
| wbSuppress | output | 1 | Older producer of the destination may skip its write-back |

## Verification
The corner cases are these. A D value of exactly zero must issue, while D = 1 must stall; an off-by-one in the timeline load would either issue early and read stale data or stall one cycle too long. A producer must vanish exactly one clock after it occupies the last stage; a design that clears late would forward from a stage that no longer holds the value. A reload onto a busy register must restart the marker, where a merged page would show two set bits. Register 0, disabled sources and the same-register forward that raises `wbSuppress` are driven directly. A random mix of back-to-back dependencies and stalls is then checked every cycle against a model that evaluates D.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // number of operand ports a candidate presents
  localparam int SRC_PORTS = 2;

  // strobes from the issue control to the page array
  typedef struct packed {
    logic loadPage;
  } pageStrobe_t;
endpackage

// File: rtl/sb_pages.sv
module sb_pages
  import sb_pkg::*;
#(
  parameter int NUM_REGS       = 32,
  parameter int NUM_STAGES     = 8,
  parameter bit ZERO_REG_CONST = 1'b1,
  localparam int RW = $clog2(NUM_REGS),
  localparam int SW = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  pageStrobe_t           strobe,
  input  logic [RW-1:0]         loadDst,
  input  logic [SW-1:0]         loadAvail,
  input  logic [RW-1:0]         rdReg0,
  input  logic [RW-1:0]         rdReg1,
  output logic [NUM_STAGES-1:0] rdUpper0,
  output logic [NUM_STAGES-1:0] rdLower0,
  output logic [NUM_STAGES-1:0] rdUpper1,
  output logic [NUM_STAGES-1:0] rdLower1
);
  localparam logic [NUM_STAGES-1:0] FIRST_STAGE = NUM_STAGES'(1);

  // position rows (single marker) and readiness rows (timeline)
  logic [NUM_STAGES-1:0] upperQ [NUM_REGS];
  logic [NUM_STAGES-1:0] lowerQ [NUM_REGS];

  // a consumer entering one cycle after the load needs stage k+1 >= avail
  function automatic logic [NUM_STAGES-1:0] availMask(input logic [SW-1:0] avail);
    logic [NUM_STAGES-1:0] m;
    for (int k = 0; k < NUM_STAGES; k++) begin
      m[k] = ((k + 1) >= int'(avail));
    end
    return m;
  endfunction

  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rst || (ZERO_REG_CONST && r == 0)) begin
        upperQ[r] <= '0;
        lowerQ[r] <= '0;
      end else if (strobe.loadPage && loadDst == RW'(r)) begin
        upperQ[r] <= FIRST_STAGE;
        lowerQ[r] <= availMask(loadAvail);
      end else begin
        upperQ[r] <= upperQ[r] << 1;
        if (upperQ[r] == '0 || upperQ[r][NUM_STAGES-1]) begin
          lowerQ[r] <= '0;
        end else begin
          lowerQ[r] <= {1'b1, lowerQ[r][NUM_STAGES-1:1]};
        end
      end
    end
  end

  assign rdUpper0 = upperQ[rdReg0];
  assign rdLower0 = lowerQ[rdReg0];
  assign rdUpper1 = upperQ[rdReg1];
  assign rdLower1 = lowerQ[rdReg1];
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int NUM_STAGES = 8,
  localparam int RW = $clog2(NUM_REGS),
  localparam int SW = $clog2(NUM_STAGES + 1)
) (
  input  logic                  issueValid,
  input  logic [RW-1:0]         issueDst,
  input  logic                  src0En,
  input  logic [RW-1:0]         src0Reg,
  input  logic [SW-1:0]         src0Need,
  input  logic [NUM_STAGES-1:0] src0Upper,
  input  logic [NUM_STAGES-1:0] src0Lower,
  input  logic                  src1En,
  input  logic [RW-1:0]         src1Reg,
  input  logic [SW-1:0]         src1Need,
  input  logic [NUM_STAGES-1:0] src1Upper,
  input  logic [NUM_STAGES-1:0] src1Lower,
  output logic                  issueOk,
  output logic [NUM_STAGES-1:0] fwdSel0,
  output logic [NUM_STAGES-1:0] fwdSel1,
  output logic                  wbSuppress,
  output pageStrobe_t           strobe
);
  logic                  enV    [SRC_PORTS];
  logic [RW-1:0]         regV   [SRC_PORTS];
  logic [SW-1:0]         needV  [SRC_PORTS];
  logic [NUM_STAGES-1:0] upperV [SRC_PORTS];
  logic [NUM_STAGES-1:0] lowerV [SRC_PORTS];
  logic [NUM_STAGES-1:0] fwdV   [SRC_PORTS];
  logic [SRC_PORTS-1:0]  srcLive, srcReady, srcSelf;
  logic                  fire;

  assign enV[0] = src0En;   assign enV[1] = src1En;
  assign regV[0] = src0Reg; assign regV[1] = src1Reg;
  assign needV[0] = src0Need; assign needV[1] = src1Need;
  assign upperV[0] = src0Upper; assign upperV[1] = src1Upper;
  assign lowerV[0] = src0Lower; assign lowerV[1] = src1Lower;

  // readiness bit for "needed at stage need"; beyond the row is always ready
  function automatic logic pickBit(input logic [NUM_STAGES-1:0] row,
                                   input logic [SW-1:0] need);
    logic b;
    b = (need == '0) ? row[0] : 1'b1;
    for (int k = 0; k < NUM_STAGES; k++) begin
      if (int'(need) == k + 1) b = row[k];
    end
    return b;
  endfunction

  for (genvar s = 0; s < SRC_PORTS; s++) begin : g_src
    assign srcLive[s]  = enV[s] && (upperV[s] != '0);
    assign srcReady[s] = !srcLive[s] || pickBit(lowerV[s], needV[s]);
    assign srcSelf[s]  = srcLive[s] && (regV[s] == issueDst);
    assign fwdV[s]     = enV[s] ? upperV[s] : '0;
  end

  assign issueOk         = &srcReady;
  assign fire            = issueValid && issueOk;
  assign strobe.loadPage = fire;
  assign wbSuppress      = fire && (|srcSelf);
  assign fwdSel0         = fwdV[0];
  assign fwdSel1         = fwdV[1];
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REGS       = 32,
  parameter int NUM_STAGES     = 8,
  parameter bit ZERO_REG_CONST = 1'b1,
  localparam int RW = $clog2(NUM_REGS),
  localparam int SW = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issueValid,
  input  logic [RW-1:0]         issueDst,
  input  logic [SW-1:0]         issueAvail,
  input  logic                  src0En,
  input  logic [RW-1:0]         src0Reg,
  input  logic [SW-1:0]         src0Need,
  input  logic                  src1En,
  input  logic [RW-1:0]         src1Reg,
  input  logic [SW-1:0]         src1Need,
  output logic                  issueOk,
  output logic [NUM_STAGES-1:0] fwdSel0,
  output logic [NUM_STAGES-1:0] fwdSel1,
  output logic                  wbSuppress
);
  pageStrobe_t           strobe;
  logic [NUM_STAGES-1:0] upper0, lower0, upper1, lower1;

  sb_pages #(
    .NUM_REGS(NUM_REGS), .NUM_STAGES(NUM_STAGES), .ZERO_REG_CONST(ZERO_REG_CONST)
  ) u_pages (
    .clk(clk), .rst(rst), .strobe(strobe),
    .loadDst(issueDst), .loadAvail(issueAvail),
    .rdReg0(src0Reg), .rdReg1(src1Reg),
    .rdUpper0(upper0), .rdLower0(lower0),
    .rdUpper1(upper1), .rdLower1(lower1)
  );

  sb_ctrl #(
    .NUM_REGS(NUM_REGS), .NUM_STAGES(NUM_STAGES)
  ) u_ctrl (
    .issueValid(issueValid), .issueDst(issueDst),
    .src0En(src0En), .src0Reg(src0Reg), .src0Need(src0Need),
    .src0Upper(upper0), .src0Lower(lower0),
    .src1En(src1En), .src1Reg(src1Reg), .src1Need(src1Need),
    .src1Upper(upper1), .src1Lower(lower1),
    .issueOk(issueOk), .fwdSel0(fwdSel0), .fwdSel1(fwdSel1),
    .wbSuppress(wbSuppress), .strobe(strobe)
  );
endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
  parameter int NUM_REGS       = 32,
  parameter int NUM_STAGES     = 8,
  parameter bit ZERO_REG_CONST = 1'b1,
  localparam int RW = $clog2(NUM_REGS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  issueValid,
  input logic [RW-1:0]         issueDst,
  input logic                  src0En,
  input logic [RW-1:0]         src0Reg,
  input logic                  src1En,
  input logic [RW-1:0]         src1Reg,
  input logic                  issueOk,
  input logic [NUM_STAGES-1:0] fwdSel0,
  input logic [NUM_STAGES-1:0] fwdSel1,
  input logic                  wbSuppress
);
  logic fire;
  assign fire = issueValid && issueOk;

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fwdSel0 == '0 && fwdSel1 == '0 && !wbSuppress)); // R1

  AST_LOAD_FIRST_STAGE: assert property (@(posedge clk) disable iff (rst)
    (fire && (!ZERO_REG_CONST || issueDst != '0)) |=>
      (!src0En || src0Reg != $past(issueDst) || fwdSel0 == NUM_STAGES'(1))); // R2

  AST_FWD_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fwdSel0) && $onehot0(fwdSel1)); // R3

  AST_FWD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (src0En && fwdSel0 != '0 && !fwdSel0[NUM_STAGES-1] && !(fire && issueDst == src0Reg)) |=>
      (!src0En || src0Reg != $past(src0Reg) || fwdSel0 == ($past(fwdSel0) << 1))); // R3

  AST_PAGE_EXPIRES: assert property (@(posedge clk) disable iff (rst)
    (src1En && fwdSel1[NUM_STAGES-1] && !(fire && issueDst == src1Reg)) |=>
      (!src1En || src1Reg != $past(src1Reg) || fwdSel1 == '0)); // R4

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
    (fwdSel0 == '0 && fwdSel1 == '0) |-> issueOk); // R5

  AST_SUPPRESS_FIRES: assert property (@(posedge clk) disable iff (rst)
    wbSuppress |-> fire); // R10

  if (ZERO_REG_CONST) begin : g_zero
    AST_ZERO_NEVER_LIVE: assert property (@(posedge clk) disable iff (rst)
      (src0Reg == '0) |-> (fwdSel0 == '0)); // R8
  end
endmodule

bind sb_scoreboard sb_scoreboard_chk #(
  .NUM_REGS(NUM_REGS), .NUM_STAGES(NUM_STAGES), .ZERO_REG_CONST(ZERO_REG_CONST)
) u_chk (
  .clk(clk), .rst(rst), .issueValid(issueValid), .issueDst(issueDst),
  .src0En(src0En), .src0Reg(src0Reg), .src1En(src1En), .src1Reg(src1Reg),
  .issueOk(issueOk), .fwdSel0(fwdSel0), .fwdSel1(fwdSel1), .wbSuppress(wbSuppress)
);

// File: tb/sb_scoreboard_tb.sv
`timescale 1ns/1ps
module sb_scoreboard_tb;
  localparam int NR = 32;
  localparam int NS = 8;
  localparam int RW = $clog2(NR);
  localparam int SW = $clog2(NS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issueValid = 1'b0;
  logic [RW-1:0] issueDst = '0;
  logic [SW-1:0] issueAvail = SW'(1);
  logic src0En = 1'b0, src1En = 1'b0;
  logic [RW-1:0] src0Reg = '0, src1Reg = '0;
  logic [SW-1:0] src0Need = SW'(1), src1Need = SW'(1);
  logic issueOk, wbSuppress;
  logic [NS-1:0] fwdSel0, fwdSel1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model: per register in-flight flag, current stage, availability stage
  bit inFlight [NR];
  int stageNow [NR];
  int availAt  [NR];

  always #2.5 clk = ~clk;

  sb_scoreboard #(.NUM_REGS(NR), .NUM_STAGES(NS), .ZERO_REG_CONST(1'b1)) u_dut (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueDst(issueDst),
    .issueAvail(issueAvail), .src0En(src0En), .src0Reg(src0Reg), .src0Need(src0Need),
    .src1En(src1En), .src1Reg(src1Reg), .src1Need(src1Need),
    .issueOk(issueOk), .fwdSel0(fwdSel0), .fwdSel1(fwdSel1), .wbSuppress(wbSuppress)
  );

  function automatic bit srcReadyRef(bit en, int r, int need);
    int d;
    if (!en || !inFlight[r]) return 1'b1;
    d = (availAt[r] - stageNow[r]) - need + 1;
    return d <= 0;
  endfunction

  function automatic logic [NS-1:0] fwdRef(bit en, int r);
    if (!en || !inFlight[r]) return '0;
    return NS'(1) << (stageNow[r] - 1);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // check outputs in the current cycle, then advance the model across the next edge
  task automatic cycle(string tag);
    bit expOk, expWbs, fireNow;
    #1;
    expOk = srcReadyRef(src0En, int'(src0Reg), int'(src0Need)) &&
            srcReadyRef(src1En, int'(src1Reg), int'(src1Need));
    fireNow = issueValid && expOk;
    expWbs = fireNow && ((src0En && inFlight[src0Reg] && src0Reg == issueDst) ||
                         (src1En && inFlight[src1Reg] && src1Reg == issueDst));
    check(tag, "issueOk", 32'(issueOk), 32'(expOk));
    check(tag, "fwdSel0", 32'(fwdSel0), 32'(fwdRef(src0En, int'(src0Reg))));
    check(tag, "fwdSel1", 32'(fwdSel1), 32'(fwdRef(src1En, int'(src1Reg))));
    check(tag, "wbSuppress", 32'(wbSuppress), 32'(expWbs));
    for (int r = 0; r < NR; r++) begin
      if (inFlight[r]) begin
        stageNow[r]++;
        if (stageNow[r] > NS) inFlight[r] = 1'b0;
      end
    end
    if (fireNow && issueDst != '0) begin
      inFlight[issueDst] = 1'b1;
      stageNow[issueDst] = 1;
      availAt[issueDst]  = int'(issueAvail);
    end
    @(negedge clk);
  endtask

  task automatic drive(bit v, int dst, int ea, bit e0, int r0, int n0, bit e1, int r1, int n1);
    issueValid = v; issueDst = RW'(dst); issueAvail = SW'(ea);
    src0En = e0; src0Reg = RW'(r0); src0Need = SW'(n0);
    src1En = e1; src1Reg = RW'(r1); src1Need = SW'(n1);
  endtask

  initial begin
    void'($urandom(32'd24681));
    for (int r = 0; r < NR; r++) begin
      inFlight[r] = 1'b0; stageNow[r] = 0; availAt[r] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: empty pages after reset
    drive(0, 0, 1, 1, 5, 1, 1, 6, 1);
    cycle("R1");
    // R2: producer to r5, result at stage 3
    drive(1, 5, 3, 0, 0, 1, 0, 0, 1);
    cycle("R11");
    // R5: producer at stage 1, need at stage 2 -> D = 1, stall
    drive(1, 9, 4, 1, 5, 2, 0, 0, 1);
    cycle("R5");
    // R6: producer at stage 2, need at stage 2 -> D = 0, issue
    drive(0, 9, 4, 1, 5, 2, 0, 0, 1);
    cycle("R6");
    // R7: disabled source naming a busy register
    drive(0, 0, 1, 0, 5, 1, 0, 5, 1);
    cycle("R7");
    // R8: load of register 0 is ignored
    drive(1, 0, 8, 0, 0, 1, 0, 0, 1);
    cycle("R8");
    drive(0, 0, 1, 1, 0, 1, 1, 5, 8);
    cycle("R8");
    // R9: reload of r5 while in flight
    drive(1, 5, 8, 0, 0, 1, 0, 0, 1);
    cycle("R9");
    drive(0, 0, 1, 1, 5, 7, 0, 0, 1);
    cycle("R9");
    // R10: consumer writes r5 and forwards r5 -> suppress
    drive(1, 5, 6, 1, 5, 8, 1, 3, 1);
    cycle("R10");
    // R4: marker walks off the last stage
    for (int i = 0; i < NS + 1; i++) begin
      drive(0, 0, 1, 1, 5, 1, 1, 5, 8);
      cycle("R4");
    end
    // R3/R5: random dependent streams over a small register window
    for (int i = 0; i < 4000; i++) begin
      drive($urandom_range(0, 9) < 7, $urandom_range(0, 7), $urandom_range(1, NS),
            $urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(1, NS),
            $urandom_range(0, 1) != 0, $urandom_range(0, 7), $urandom_range(1, NS));
      cycle("R5");
    end
    // R1: reset mid-stream clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < NR; r++) inFlight[r] = 1'b0;
    drive(0, 0, 1, 1, 3, 1, 1, 4, 1);
    cycle("R1");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule